// File: doc/BRIEF.md
# Memory Test Pattern Generator

This block supplies the data for a built-in memory self-test engine on a 72-bit DDR data path. Each access carries two beats, early and late, and each beat holds 8 check bits and 64 data bits. The pattern comes from a 160-bit state built from five 32-bit words. A start pulse loads the first word from a 32-bit seed and clears the other four. Each time the engine consumes a pattern, an advance pulse steps the state once.

The state can step in two ways. In ring mode the five words form a closed 160-bit loop, and each word rotates left by one bit as it passes to the next. In LFSR mode the first word instead takes one CRC-32 step of itself, and the rest of the chain still rotates. A global invert input flips all 144 presented bits.

On a write the test engine drives the two beats onto the bus. On a read the same beats act as expected values. A compare enable then checks them lane by lane against the received beats. Mismatches collect in a sticky per-lane error vector with a summary flag, and the next start pulse clears both.

Top module: `mtpg_top`

## Requirements
- R1: While reset is asserted, the internal state and the error vector are zero. With invert low, both beats read all zeros and err_o is low.
- R2: A start pulse loads seed_i into word 0 and clears words 1 to 4, so the next pattern has only check bits from the seed. The early beat is {seed[7:0], 64'h0} and the late beat is {seed[15:8], 64'h0}.
- R3: When start and advance are high together, start takes priority and the seed load of R2 occurs.
- R4: In ring mode, each advance sets word k to rotate-left-1 of old word k-1 for k = 1..4, and sets word 0 to rotate-left-1 of old word 4. A bit leaving position 31 enters position 0.
- R5: The beat bit order is [71:64] check bits and [63:0] data. The early beat is {w0[7:0], w2, w1} and the late beat is {w0[15:8], w4, w3}, where wN is word N.
- R6: When invert_i is high, all 144 presented bits are the complement of the R5 mapping, and the complemented values are also the ones used for compare.
- R7: In LFSR mode, each advance sets word 0 to {w0[30:0],1'b0} XOR (w0[31] ? 32'h04C11DB7 : 0), while words 1 to 4 still follow R4.
- R8: With neither start nor advance high, the state and both beats hold.
- R9: When cmp_en_i is high at a clock edge, err_lane_o bit i is set if bit i of either received beat differs from the presented beat. The bit is visible from the next cycle and stays set (sticky).
- R10: A start pulse clears err_lane_o and err_o from the next cycle. err_o is high whenever any bit of err_lane_o is set.
- R11: With cmp_en_i low, mismatching received data leaves err_lane_o unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| seed_i | input | 32 | Seed word |
| start_i | input | 1 | Start of test: load seed, clear errors |
| advance_i | input | 1 | Pattern consumed: step state |
| lfsr_mode_i | input | 1 | 1 = CRC-32 step for word 0, 0 = closed ring |
| invert_i | input | 1 | Complement all presented bits |
| cmp_en_i | input | 1 | Compare received beats this cycle |
| rd_early_i | input | 72 | Received early beat |
| rd_late_i | input | 72 | Received late beat |
| wr_early_o | output | 72 | Generated early beat |
| wr_late_o | output | 72 | Generated late beat |
| err_lane_o | output | 72 | Sticky per-lane mismatch |
| err_o | output | 1 | Any lane mismatched |

## Verification
The beats are combinational from the state register, so a start or advance applied before an edge shows on the beats one edge later. Invert has no delay and shows in the same cycle. Error bits are registered, so a compare in cycle n is visible in cycle n+1, and a start clears them at that same edge. The bench drives inputs on the falling edge and updates its own arithmetic model at the same moment. It waits exactly one falling edge and then compares the beats and errors against the model. The bench sweeps long ring and LFSR runs plus targeted lane flips.

// File: rtl/mtpg_pkg.sv
package mtpg_pkg;
   localparam int unsigned DEF_REG_W = 32;
   localparam int unsigned DEF_CB_W  = 8;
   localparam int unsigned DEF_DQ_W  = 64;
   localparam logic [31:0] DEF_POLY  = 32'h04C11DB7;

   typedef enum logic {
      SRC_RING = 1'b0,
      SRC_LFSR = 1'b1
   } nxt_src_e;
endpackage

// File: rtl/mtpg_state.sv
module mtpg_state
   import mtpg_pkg::*;
#(
   parameter int unsigned REG_W    = DEF_REG_W,
   parameter int unsigned NUM_REGS = 5,
   parameter logic [REG_W-1:0] POLY = DEF_POLY,
   parameter bit LFSR_EN = 1'b1,
   localparam int unsigned STATE_W = REG_W * NUM_REGS
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [REG_W-1:0]   seed_i,
   input  logic               load_i,
   input  logic               adv_i,
   input  logic               lfsr_i,
   output logic [STATE_W-1:0] state_o
);
   function automatic logic [REG_W-1:0] rotl1(input logic [REG_W-1:0] x);
      return {x[REG_W-2:0], x[REG_W-1]};
   endfunction

   function automatic logic [REG_W-1:0] crc_step(input logic [REG_W-1:0] x);
      return {x[REG_W-2:0], 1'b0} ^ (x[REG_W-1] ? POLY : '0);
   endfunction

   logic [REG_W-1:0] w_q [NUM_REGS];
   logic [REG_W-1:0] w_d [NUM_REGS];
   nxt_src_e         src;

   generate
      if (LFSR_EN) begin : g_lfsr_sel
         assign src = lfsr_i ? SRC_LFSR : SRC_RING;
      end else begin : g_ring_only
         logic unused_lfsr;
         assign unused_lfsr = lfsr_i;
         assign src = SRC_RING;
      end
   endgenerate

   // head word: either closes the ring or takes a CRC step
   always_comb begin
      if (src == SRC_LFSR) w_d[0] = crc_step(w_q[0]);
      else                 w_d[0] = rotl1(w_q[NUM_REGS-1]);
   end

   genvar g;
   generate
      for (g = 1; g < NUM_REGS; g++) begin : g_link
         assign w_d[g] = rotl1(w_q[g-1]);
      end
      for (g = 0; g < NUM_REGS; g++) begin : g_word
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      w_q[g] <= '0;
            else if (load_i) w_q[g] <= (g == 0) ? seed_i : '0;
            else if (adv_i)  w_q[g] <= w_d[g];
         end
         assign state_o[g*REG_W +: REG_W] = w_q[g];
      end
   endgenerate
endmodule

// File: rtl/mtpg_map.sv
module mtpg_map #(
   parameter int unsigned CB_W = 8,
   parameter int unsigned DQ_W = 64,
   localparam int unsigned BEAT_W = CB_W + DQ_W
) (
   input  logic [2*CB_W-1:0] cb_src_i,
   input  logic [2*DQ_W-1:0] dq_src_i,
   input  logic              invert_i,
   output logic [BEAT_W-1:0] early_o,
   output logic [BEAT_W-1:0] late_o
);
   logic [BEAT_W-1:0] flip;
   assign flip    = {BEAT_W{invert_i}};
   assign early_o = {cb_src_i[CB_W-1:0],      dq_src_i[DQ_W-1:0]}      ^ flip;
   assign late_o  = {cb_src_i[2*CB_W-1:CB_W], dq_src_i[2*DQ_W-1:DQ_W]} ^ flip;
endmodule

// File: rtl/mtpg_cmp.sv
module mtpg_cmp #(
   parameter int unsigned BEAT_W = 72
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr_i,
   input  logic              en_i,
   input  logic [BEAT_W-1:0] exp_early_i,
   input  logic [BEAT_W-1:0] exp_late_i,
   input  logic [BEAT_W-1:0] rd_early_i,
   input  logic [BEAT_W-1:0] rd_late_i,
   output logic [BEAT_W-1:0] err_lane_o,
   output logic              err_any_o
);
   logic [BEAT_W-1:0] miss;
   logic [BEAT_W-1:0] err_q;

   assign miss = (exp_early_i ^ rd_early_i) | (exp_late_i ^ rd_late_i);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     err_q <= '0;
      else if (clr_i) err_q <= '0;
      else if (en_i)  err_q <= err_q | miss;
   end

   assign err_lane_o = err_q;
   assign err_any_o  = |err_q;
endmodule

// File: rtl/mtpg_top.sv
module mtpg_top
   import mtpg_pkg::*;
#(
   parameter int unsigned REG_W = DEF_REG_W,
   parameter int unsigned CB_W  = DEF_CB_W,
   parameter int unsigned DQ_W  = DEF_DQ_W,
   parameter logic [REG_W-1:0] POLY = DEF_POLY,
   parameter bit LFSR_EN = 1'b1,
   localparam int unsigned BEAT_W   = CB_W + DQ_W,
   localparam int unsigned NUM_REGS = 1 + 2 * (DQ_W / REG_W),
   localparam int unsigned STATE_W  = REG_W * NUM_REGS
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [REG_W-1:0]  seed_i,
   input  logic              start_i,
   input  logic              advance_i,
   input  logic              lfsr_mode_i,
   input  logic              invert_i,
   input  logic              cmp_en_i,
   input  logic [BEAT_W-1:0] rd_early_i,
   input  logic [BEAT_W-1:0] rd_late_i,
   output logic [BEAT_W-1:0] wr_early_o,
   output logic [BEAT_W-1:0] wr_late_o,
   output logic [BEAT_W-1:0] err_lane_o,
   output logic              err_o
);
   localparam bit CFG_OK = (DQ_W % REG_W == 0) && (2 * CB_W <= REG_W) && (REG_W >= 2);

   initial begin
      if (!CFG_OK) $fatal(1, "mtpg_top: DQ_W must be a multiple of REG_W and 2*CB_W <= REG_W");
   end

   logic [STATE_W-1:0] state_q;

   mtpg_state #(
      .REG_W(REG_W), .NUM_REGS(NUM_REGS), .POLY(POLY), .LFSR_EN(LFSR_EN)
   ) state_i (
      .clk(clk), .rst_n(rst_n), .seed_i(seed_i), .load_i(start_i),
      .adv_i(advance_i), .lfsr_i(lfsr_mode_i), .state_o(state_q)
   );

   mtpg_map #(.CB_W(CB_W), .DQ_W(DQ_W)) map_i (
      .cb_src_i(state_q[2*CB_W-1:0]),
      .dq_src_i(state_q[STATE_W-1:REG_W]),
      .invert_i(invert_i),
      .early_o(wr_early_o),
      .late_o(wr_late_o)
   );

   mtpg_cmp #(.BEAT_W(BEAT_W)) cmp_i (
      .clk(clk), .rst_n(rst_n), .clr_i(start_i), .en_i(cmp_en_i),
      .exp_early_i(wr_early_o), .exp_late_i(wr_late_o),
      .rd_early_i(rd_early_i), .rd_late_i(rd_late_i),
      .err_lane_o(err_lane_o), .err_any_o(err_o)
   );
endmodule

// File: rtl/mtpg_chk.sv
module mtpg_chk #(
   parameter int unsigned REG_W   = 32,
   parameter int unsigned STATE_W = 160,
   parameter int unsigned BEAT_W  = 72,
   parameter logic [REG_W-1:0] POLY = 32'h04C11DB7
) (
   input logic               clk,
   input logic               rst_n,
   input logic [REG_W-1:0]   seed_i,
   input logic               start_i,
   input logic               advance_i,
   input logic               lfsr_mode_i,
   input logic               cmp_en_i,
   input logic [STATE_W-1:0] state,
   input logic [BEAT_W-1:0]  err_lane
);
   a_r2_seed_load: assert property (@(posedge clk) disable iff (!rst_n)
      start_i |=> (state[REG_W-1:0] == $past(seed_i)) && (state[STATE_W-1:REG_W] == '0));

   a_r3_start_wins: assert property (@(posedge clk) disable iff (!rst_n)
      (start_i && advance_i) |=> state[REG_W-1:0] == $past(seed_i));

   a_r4_ring_link: assert property (@(posedge clk) disable iff (!rst_n)
      (!start_i && advance_i) |=>
         state[2*REG_W-1:REG_W] == {$past(state[REG_W-2:0]), $past(state[REG_W-1])});

   a_r4_ring_close: assert property (@(posedge clk) disable iff (!rst_n)
      (!start_i && advance_i && !lfsr_mode_i) |=>
         state[REG_W-1:0] == {$past(state[STATE_W-2:STATE_W-REG_W]), $past(state[STATE_W-1])});

   a_r7_lfsr_step: assert property (@(posedge clk) disable iff (!rst_n)
      (!start_i && advance_i && lfsr_mode_i) |=>
         state[REG_W-1:0] == ({$past(state[REG_W-2:0]), 1'b0} ^ ($past(state[REG_W-1]) ? POLY : '0)));

   a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!start_i && !advance_i) |=> $stable(state));

   a_r9_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      !start_i |=> ((err_lane & $past(err_lane)) == $past(err_lane)));

   a_r10_clear: assert property (@(posedge clk) disable iff (!rst_n)
      start_i |=> err_lane == '0);

   a_r11_idle: assert property (@(posedge clk) disable iff (!rst_n)
      (!start_i && !cmp_en_i) |=> $stable(err_lane));
endmodule

bind mtpg_top mtpg_chk #(
   .REG_W(REG_W), .STATE_W(STATE_W), .BEAT_W(BEAT_W), .POLY(POLY)
) chk_i (
   .clk(clk), .rst_n(rst_n), .seed_i(seed_i), .start_i(start_i),
   .advance_i(advance_i), .lfsr_mode_i(lfsr_mode_i), .cmp_en_i(cmp_en_i),
   .state(state_q), .err_lane(err_lane_o)
);

// File: tb/mtpg_top_tb_top.sv
`timescale 1ns/1ps
module mtpg_top_tb_top;
   localparam logic [31:0] POLY = 32'h04C11DB7;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] seed = '0;
   logic        start = 1'b0, adv = 1'b0, lfsr = 1'b0, inv = 1'b0, cmp = 1'b0;
   logic [71:0] rd_e = '0, rd_l = '0;
   logic [71:0] wr_e, wr_l, err_lane;
   logic        err;

   int checks = 0;
   int fails  = 0;

   logic [31:0] m [5];
   logic [71:0] m_err;

   always #2 clk = ~clk;

   mtpg_top dut_i (
      .clk(clk), .rst_n(rst_n), .seed_i(seed), .start_i(start), .advance_i(adv),
      .lfsr_mode_i(lfsr), .invert_i(inv), .cmp_en_i(cmp),
      .rd_early_i(rd_e), .rd_late_i(rd_l),
      .wr_early_o(wr_e), .wr_late_o(wr_l), .err_lane_o(err_lane), .err_o(err)
   );

   function automatic logic [31:0] rotl(input logic [31:0] x);
      return {x[30:0], x[31]};
   endfunction

   function automatic logic [31:0] crc(input logic [31:0] x);
      return {x[30:0], 1'b0} ^ (x[31] ? POLY : 32'h0);
   endfunction

   function automatic logic [71:0] exp_e();
      return {m[0][7:0], m[2], m[1]} ^ {72{inv}};
   endfunction

   function automatic logic [71:0] exp_l();
      return {m[0][15:8], m[4], m[3]} ^ {72{inv}};
   endfunction

   task automatic chk(input bit ok, input string tag, input logic [215:0] act, input logic [215:0] expv);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s act=%h exp=%h", tag, act, expv);
      end
   endtask

   task automatic check_all(input string tag);
      chk({wr_e, wr_l, err_lane} === {exp_e(), exp_l(), m_err} && err === (m_err != 0),
          tag, {wr_e, wr_l, err_lane}, {exp_e(), exp_l(), m_err});
   endtask

   // inputs already set at a falling edge; update the model, pass one edge
   task automatic step();
      logic [31:0] o [5];
      if (start) m_err = '0;
      else if (cmp) m_err = m_err | (exp_e() ^ rd_e) | (exp_l() ^ rd_l);
      for (int k = 0; k < 5; k++) o[k] = m[k];
      if (start) begin
         m[0] = seed;
         for (int k = 1; k < 5; k++) m[k] = '0;
      end else if (adv) begin
         m[0] = lfsr ? crc(o[0]) : rotl(o[4]);
         for (int k = 1; k < 5; k++) m[k] = rotl(o[k-1]);
      end
      @(negedge clk);
   endtask

   task automatic drive(input bit s, input bit a, input bit c);
      start = s; adv = a; cmp = c;
      step();
      start = 1'b0; adv = 1'b0; cmp = 1'b0;
   endtask

   initial begin
      #800000;
      checks++; fails++;
      $display("FAIL watchdog expired act=running exp=done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      for (int k = 0; k < 5; k++) m[k] = '0;
      m_err = '0;
      repeat (3) @(negedge clk);
      check_all("R1 reset state");
      rst_n = 1'b1;
      @(negedge clk);

      // R2: seed load, check-bit only pattern
      seed = 32'h8000_A501;
      drive(1, 0, 0);
      chk({wr_e, wr_l} === {8'h01, 64'h0, 8'hA5, 64'h0}, "R2 seed load",
          {72'h0, wr_e, wr_l}, {72'h0, 8'h01, 64'h0, 8'hA5, 64'h0});
      check_all("R2 model after start");

      // R8: hold
      for (int i = 0; i < 3; i++) begin
         drive(0, 0, 0);
         check_all("R8 hold without advance");
      end

      // R4/R5: first advance, explicit rotated word in early data low half
      drive(0, 1, 0);
      chk(wr_e[31:0] === 32'h0001_4A03, "R5 early dq low word", {184'h0, wr_e[31:0]}, {184'h0, 32'h0001_4A03});
      check_all("R4 first advance");

      // R4: long ring sweep, invert toggled part way (R6)
      for (int i = 0; i < 170; i++) begin
         inv = (i >= 100 && i < 130);
         drive(0, 1, 0);
         check_all(inv ? "R6 inverted ring pattern" : "R4 ring sweep");
      end
      inv = 1'b1;
      #0;
      check_all("R6 invert same cycle");
      inv = 1'b0;

      // R3: start and advance together
      seed = 32'h1234_5678;
      drive(1, 1, 0);
      chk({wr_e, wr_l} === {8'h78, 64'h0, 8'h56, 64'h0}, "R3 start wins",
          {72'h0, wr_e, wr_l}, {72'h0, 8'h78, 64'h0, 8'h56, 64'h0});

      // R7: LFSR from seed 1, after 32 steps word 0 equals the polynomial
      seed = 32'h0000_0001;
      drive(1, 0, 0);
      lfsr = 1'b1;
      for (int i = 0; i < 32; i++) begin
         drive(0, 1, 0);
         check_all("R7 lfsr sweep");
      end
      chk({wr_e[71:64], wr_l[71:64]} === 16'h1DB7 || {wr_l[71:64], wr_e[71:64]} === 16'h1DB7,
          "R7 poly reached", {200'h0, wr_l[71:64], wr_e[71:64]}, {200'h0, 16'h1DB7});
      for (int i = 0; i < 60; i++) begin
         drive(0, 1, 0);
         check_all("R7 lfsr long run");
      end
      lfsr = 1'b0;

      // R9: matching read gives no error
      seed = 32'hDEAD_BEEF;
      drive(1, 0, 0);
      for (int i = 0; i < 10; i++) begin
         rd_e = exp_e(); rd_l = exp_l();
         drive(0, 1, 1);
         check_all("R9 clean compare");
      end
      chk(err === 1'b0, "R9 no error on match", {215'h0, err}, 216'h0);

      // R9: single lane flips in each beat
      rd_e = exp_e() ^ (72'h1 << 5);
      rd_l = exp_l() ^ (72'h1 << 70);
      drive(0, 1, 1);
      chk(err_lane === ((72'h1 << 5) | (72'h1 << 70)) && err === 1'b1, "R9 lane flags",
          {144'h0, err_lane}, {144'h0, (72'h1 << 5) | (72'h1 << 70)});
      check_all("R9 lane model");

      // R9: sticky under a later clean compare
      rd_e = exp_e(); rd_l = exp_l();
      drive(0, 1, 1);
      check_all("R9 sticky");

      // R11: mismatch with compare disabled
      rd_e = exp_e() ^ (72'h1 << 9);
      drive(0, 1, 0);
      chk(err_lane === ((72'h1 << 5) | (72'h1 << 70)), "R11 compare disabled",
          {144'h0, err_lane}, {144'h0, (72'h1 << 5) | (72'h1 << 70)});

      // R6: inverted compare, each lane swept
      inv = 1'b1;
      for (int l = 0; l < 72; l++) begin
         drive(1, 0, 0);
         check_all("R10 start clears");
         rd_e = exp_e() ^ (72'h1 << l);
         rd_l = exp_l();
         drive(0, 0, 1);
         chk(err_lane === (72'h1 << l) && err === 1'b1, "R6 inverted lane compare",
             {144'h0, err_lane}, {144'h0, 72'h1 << l});
      end
      inv = 1'b0;

      // R10: clear and summary low
      drive(1, 0, 0);
      chk(err_lane === '0 && err === 1'b0, "R10 clear", {143'h0, err, err_lane}, 216'h0);

      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule